// File: doc/BRIEF.md
# Return-to-Zero Differential FIR DAC Driver

This block turns a one-bit oversampled audio stream into two banks of flip-flop outputs. An external network of equal resistors sums those outputs and forms a semi-digital FIR DAC. Every accepted data bit is followed by a forced zero slot, so the stream is return-to-zero. The stream moves through a tap delay line that is clocked at twice the bit rate. Because the taps are half a bit period apart, the four equal taps together span two bit periods.

Two complementary phases are generated. In a data slot, the positive phase carries the data bit and the negative phase carries its inverse. In a zero slot, both phases are low. Each bank holds every tap of both phases, and the two banks interleave the phases in opposite order. Each phase is therefore spread over eight outputs, four in each bank, and every tap is driven by two independent flip-flops. The positive-phase resistor sum and the negative-phase resistor sum are in antiphase, and an analog stage downstream subtracts them.

A small slot state machine makes the return-to-zero encoding. It has three states:
- IDLE: no data has arrived since reset.
- DATA: the current slot carries a bit.
- ZERO: the current slot is the forced or idle zero.

Its transitions are:
- IDLE→DATA and ZERO→DATA on an accepted strobe.
- IDLE→IDLE and ZERO→ZERO when there is no strobe.
- DATA→ZERO always.

Top module: `rtz_fir_dac_driver`

## Requirements
- R1: A synchronous reset clears every output flip-flop, so both banks read all zeros in the cycle after a clock edge with `rst` high.
- R2: A clock edge with `bit_stb` high that is accepted loads a data slot into the encoder. One edge later, tap 0 shows positive phase = `din` and negative phase = not `din`.
- R3: The slot that follows a data slot is always a zero slot. A strobe seen at the edge right after an accepted strobe is ignored.
- R4: An edge with `bit_stb` low produces a zero slot, in which both phases are 0.
- R5: Tap k+1 holds the value that tap k held one clock earlier. A bit sampled at edge E reaches tap k after edge E+1+k.
- R6: For tap k, the bank bits are mapped as follows: `bank_a[2k]` = positive phase, `bank_a[2k+1]` = negative phase, `bank_b[2k]` = negative phase, `bank_b[2k+1]` = positive phase.
- R7: The two phases are never both high in the same tap.
- R8: (Ones in the positive group) minus (ones in the negative group) equals twice the moving sum of the last TAPS slots. In that sum a data 1 counts +1, a data 0 counts −1 and a zero slot counts 0. The positive group is the even bits of `bank_a` and the odd bits of `bank_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | Marks the data half-slot; `din` is sampled when it is high |
| din | input | 1 | Serial data bit |
| bank_a | output | 2*TAPS | First output bank: even bits positive phase, odd bits negative phase |
| bank_b | output | 2*TAPS | Second output bank: even bits negative phase, odd bits positive phase |

## Verification
The bench holds `bit_stb` high for many edges in a row. A design that accepts every strobe would put two data slots next to each other, which breaks return-to-zero and doubles the energy in the taps.

Long gaps without a strobe check that idle slots produce zeros on both phases. A design that held the last bit, or drove the inverse during zero slots, would show a nonzero differential sum in these gaps.

The reference model compares every bank bit on every cycle. This catches a swapped bank interleave and an off-by-one latency in the delay line.

A reset in the middle of a run checks that every copy of every tap clears at the same time.

// File: rtl/rtz_dac_pkg.sv
package rtz_dac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_ZERO = 2'd2
    } slot_state_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } rtz_pair_t;

endpackage

// File: rtl/rtz_slot_encoder.sv
module rtz_slot_encoder
    import rtz_dac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_stb,
    input  logic        din,
    output rtz_pair_t   slot_q,
    output slot_state_t state_q
);

    slot_state_t state_nx;
    logic        accept;

    // A strobe is refused while a data slot is current: a zero must follow.
    assign accept = bit_stb && (state_q != ST_DATA);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = accept ? ST_DATA : ST_IDLE;
            ST_DATA: state_nx = ST_ZERO;
            ST_ZERO: state_nx = accept ? ST_DATA : ST_ZERO;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (accept) begin
            slot_q.pos <= din;
            slot_q.neg <= ~din;
        end else begin
            slot_q <= '0;
        end
    end

endmodule

// File: rtl/rtz_tap_bank.sv
module rtz_tap_bank
    import rtz_dac_pkg::*;
#(
    parameter int TAPS       = 4,
    parameter bit POS_ON_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  rtz_pair_t         slot_in,
    output logic [2*TAPS-1:0] bank_q
);

    localparam int WIDTH = 2 * TAPS;

    logic [TAPS-1:0] pos_sr;
    logic [TAPS-1:0] neg_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_sr <= '0;
            neg_sr <= '0;
        end else begin
            pos_sr[0] <= slot_in.pos;
            neg_sr[0] <= slot_in.neg;
            for (int k = 1; k < TAPS; k++) begin
                pos_sr[k] <= pos_sr[k-1];
                neg_sr[k] <= neg_sr[k-1];
            end
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (POS_ON_ODD) begin : g_odd
            assign bank_q[2*k]   = neg_sr[k];
            assign bank_q[2*k+1] = pos_sr[k];
        end else begin : g_even
            assign bank_q[2*k]   = pos_sr[k];
            assign bank_q[2*k+1] = neg_sr[k];
        end
    end

    if (WIDTH != 2 * TAPS) begin : g_bad_width
        initial $display("rtz_tap_bank: width mismatch");
    end

endmodule

// File: rtl/rtz_fir_dac_driver.sv
module rtz_fir_dac_driver
    import rtz_dac_pkg::*;
#(
    parameter int TAPS = 4
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              din,
    output logic [2*TAPS-1:0] bank_a,
    output logic [2*TAPS-1:0] bank_b
);

    rtz_pair_t   enc_slot;
    slot_state_t enc_state;

    rtz_slot_encoder u_enc (
        .clk     (clk2x),
        .rst     (rst),
        .bit_stb (bit_stb),
        .din     (din),
        .slot_q  (enc_slot),
        .state_q (enc_state)
    );

    // Two independent banks: each tap is carried by one flip-flop per bank.
    rtz_tap_bank #(.TAPS(TAPS), .POS_ON_ODD(1'b0)) u_bank_a (
        .clk     (clk2x),
        .rst     (rst),
        .slot_in (enc_slot),
        .bank_q  (bank_a)
    );

    rtz_tap_bank #(.TAPS(TAPS), .POS_ON_ODD(1'b1)) u_bank_b (
        .clk     (clk2x),
        .rst     (rst),
        .slot_in (enc_slot),
        .bank_q  (bank_b)
    );

endmodule

// File: rtl/rtz_fir_dac_checker.sv
module rtz_fir_dac_checker
    import rtz_dac_pkg::*;
#(
    parameter int TAPS = 4
) (
    input logic              clk2x,
    input logic              rst,
    input logic              bit_stb,
    input logic [2*TAPS-1:0] bank_a,
    input logic [2*TAPS-1:0] bank_b,
    input slot_state_t       enc_state
);

    p_reset_clear_r1: assert property (@(posedge clk2x)
        rst |=> (bank_a == '0 && bank_b == '0));

    p_tap0_needs_strobe_r2: assert property (@(posedge clk2x) disable iff (rst)
        (bank_a[0] || bank_a[1]) |-> $past(bit_stb, 2));

    p_data_then_zero_r3: assert property (@(posedge clk2x) disable iff (rst)
        (enc_state == ST_DATA) |=> (enc_state == ST_ZERO));

    for (genvar k = 0; k < TAPS; k++) begin : g_chk
        p_no_overlap_r7: assert property (@(posedge clk2x) disable iff (rst)
            !(bank_a[2*k] && bank_a[2*k+1]));

        p_banks_agree_r6: assert property (@(posedge clk2x) disable iff (rst)
            (bank_b[2*k+1] == bank_a[2*k]) && (bank_b[2*k] == bank_a[2*k+1]));

        if (k > 0) begin : g_shift
            p_shift_r5: assert property (@(posedge clk2x) disable iff (rst)
                bank_a[2*k+1 -: 2] == $past(bank_a[2*k-1 -: 2]));
        end
    end

endmodule

bind rtz_fir_dac_driver rtz_fir_dac_checker #(.TAPS(TAPS)) u_checker (
    .clk2x     (clk2x),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .bank_a    (bank_a),
    .bank_b    (bank_b),
    .enc_state (enc_state)
);

// File: tb/rtz_fir_dac_driver_test.sv
module rtz_fir_dac_driver_test;

    localparam int TAPS     = 4;
    localparam int CLK_HALF = 5;

    logic              clk2x = 1'b0;
    logic              rst   = 1'b1;
    logic              bit_stb = 1'b0;
    logic              din   = 1'b0;
    logic [2*TAPS-1:0] bank_a;
    logic [2*TAPS-1:0] bank_b;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;
    string cur_req = "R1";

    always #(CLK_HALF) clk2x = ~clk2x;

    rtz_fir_dac_driver #(.TAPS(TAPS)) uut (
        .clk2x   (clk2x),
        .rst     (rst),
        .bit_stb (bit_stb),
        .din     (din),
        .bank_a  (bank_a),
        .bank_b  (bank_b)
    );

    // Reference: hist[0] is the encoder slot, hist[k+1] is tap k (+1, -1, 0).
    int hist [0:TAPS];
    bit last_data = 0;

    always @(posedge clk2x) begin
        if (rst) begin
            for (int i = 0; i <= TAPS; i++) hist[i] = 0;
            last_data = 0;
        end else begin
            for (int i = TAPS; i > 0; i--) hist[i] = hist[i-1];
            if (bit_stb && !last_data) begin
                hist[0] = din ? 1 : -1;
                last_data = 1;
            end else begin
                hist[0] = 0;
                last_data = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [2*TAPS-1:0] ea, eb;
        int pos_ones, neg_ones, msum;
        bit overlap;
        pos_ones = 0; neg_ones = 0; msum = 0; overlap = 0;
        for (int k = 0; k < TAPS; k++) begin
            ea[2*k]   = (hist[k+1] == 1);
            ea[2*k+1] = (hist[k+1] == -1);
            eb[2*k]   = (hist[k+1] == -1);
            eb[2*k+1] = (hist[k+1] == 1);
            msum += hist[k+1];
            pos_ones += int'(bank_a[2*k]) + int'(bank_b[2*k+1]);
            neg_ones += int'(bank_a[2*k+1]) + int'(bank_b[2*k]);
            if (bank_a[2*k] && bank_a[2*k+1]) overlap = 1;
            if (bank_b[2*k] && bank_b[2*k+1]) overlap = 1;
        end
        check({cur_req, " R5 R6 bank_a"}, int'(bank_a), int'(ea));
        check({cur_req, " R5 R6 bank_b"}, int'(bank_b), int'(eb));
        check("R8 differential sum", pos_ones - neg_ones, 2 * msum);
        check("R7 phase overlap", int'(overlap), 0);
    endtask

    task automatic step(input bit stb, input bit d);
        @(negedge clk2x);
        compare_all();
        bit_stb = stb;
        din     = d;
    endtask

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (3) step(1'b0, 1'b0);
        check("R1 bank_a after reset", int'(bank_a), 0);
        check("R1 bank_b after reset", int'(bank_b), 0);
        @(negedge clk2x);
        rst = 1'b0;

        // R4: idle, no strobe
        cur_req = "R4";
        repeat (8) step(1'b0, 1'b1);

        // R2: regular alternating strobe with a fixed pattern
        cur_req = "R2";
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 1'(((i * 5) >> 1) & 1));
            step(1'b0, 1'b0);
        end

        // R3: strobe held high, every second one must be refused
        cur_req = "R3";
        for (int i = 0; i < 20; i++) step(1'b1, 1'(i % 3 == 0));
        step(1'b0, 1'b0);
        // directed: one accepted bit of 1, then ignored strobe of 0
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        // tap0 now shows the 1, encoder slot is the forced zero
        check("R3 tap0 holds accepted one", int'(bank_a[1:0]), 1);
        step(1'b0, 1'b0);
        check("R3 tap0 zero after data", int'(bank_a[1:0]), 0);
        check("R5 tap1 shifted one", int'(bank_a[3:2]), 1);

        // R2/R4: random gaps and data
        cur_req = "R2 R4";
        for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)));

        // R1: reset in the middle of a run
        cur_req = "R1";
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        rst = 1'b1;
        step(1'b1, 1'b0);
        check("R1 mid-run clear bank_a", int'(bank_a), 0);
        check("R1 mid-run clear bank_b", int'(bank_b), 0);
        @(negedge clk2x);
        rst = 1'b0;
        cur_req = "R2";
        for (int i = 0; i < 16; i++) step(1'b1, 1'(i & 1));
        step(1'b0, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk2x);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule